// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous static memory of parameterised depth. Its port arrangement lets a bus master issue a read or a write on every clock edge, in any mix, without idle cycles between them. The address, the cycle type, the byte-lane write enables and the three chip selects are all captured at the rising clock edge. A read leaves through an output register. A write takes its data two edges after its address, the same distance a read needs to return data. A master can therefore run any sequence of reads and writes on one command slot per cycle.

A two-bit burst counter supplies the low address bits. An advance input continues the current cycle type from its base address, either in linear order or in interleaved order. A clock enable freezes the whole pipeline. An asynchronous output enable gates the data outputs. An asynchronous sleep input blocks new cycles. A read that hits a write still waiting for its data returns the new bytes merged over the stored ones.

Top module: `ntsram_top`

## Requirements
- R1: After reset no cycle is pending and `q_drive` is 0 with `q` equal to 0.
- R2: A read accepted at enabled edge N has its word on `q`, with `q_drive` at 1, from enabled edge N+1 until the next enabled edge.
- R3: A write accepted at enabled edge N stores the word present on `wdata` at enabled edge N+2. Only byte lanes whose `byte_we` bit was 1 at edge N are stored, where lane k is bits 9k+8 down to 9k.
- R4: Reads and writes may be issued on consecutive enabled edges in any order with no idle cycle, and each one completes correctly.
- R5: A read whose address equals that of the write completing at the edge that loads the read's output register returns the new `wdata` bytes for the enabled lanes and the stored bytes for the others.
- R6: While `clk_en` is 0 every pipeline stage, the output register and the array hold their state, and the commands on the inputs are ignored.
- R7: A cycle is accepted only when `sel_a` is 1, `sel_b` is 1 and `sel_c_n` is 0. Otherwise the edge is a deselect: nothing is written and nothing is driven one edge later.
- R8: With `adv` at 1 after an accepted cycle, the previous cycle type and base address are reused, the beat counter steps by one and wraps after four beats, and the address, selects and `wr_sel` are ignored. After a deselect, `adv` starts nothing.
- R9: With `burst_ilv` at 0 the low two address bits are the base low bits plus the beat count, modulo 4.
- R10: With `burst_ilv` at 1 the low two address bits are the base low bits XOR the beat count.
- R11: When `oe` is 0, `q_drive` is 0 and `q` is 0 at once, with no clock edge needed. Raising `oe` again shows the held word.
- R12: While `sleep` is 1 no new or burst cycle is accepted, so nothing is written or read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Pipeline clock enable, 1 = advance |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_sel | input | 1 | Cycle type, 1 = write, 0 = read |
| adv | input | 1 | Continue burst from the previous cycle |
| burst_ilv | input | 1 | Burst order, 1 = interleaved, 0 = linear |
| byte_we | input | LANES | Byte-lane write enables, one per 9-bit lane |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled two edges after its address |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down request |
| q | output | LANES*LANE_W | Read data, 0 when not driven |
| q_drive | output | 1 | Data outputs actively driven (0 = high impedance) |

## Verification
The main function is tried with alternating write/write/read/read and read/write/write/read streams. These separate a correct two-edge write-data offset from an off-by-one, and they show that no idle slot is needed when the direction changes. A read placed right behind a partial-lane write to the same word shows whether forwarding and lane masking are both correct. Bursts starting at a base whose low bits are 01 give different address sequences for linear and interleaved order, and a fifth beat shows the wrap. Suspended, deselected and sleeping edges that carry a conflicting write to a known word are followed by a read of that word, which shows that those edges had no effect.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;

  // Kind of cycle held in a pipeline stage
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_RD   = 2'd1,
    CYC_WR   = 2'd2
  } cyc_e;

  // Low two address bits of a burst beat
  function automatic logic [1:0] burst_lsb(input logic [1:0] base,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/ntsram_ctrl.sv
module ntsram_ctrl
  import ntsram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             sleep,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_sel,
  input  logic             adv,
  input  logic             ilv,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  output logic             rd_fire,
  output logic [AW-1:0]    rd_addr,
  output logic             wr_fire,
  output logic [AW-1:0]    wr_addr,
  output logic [LANES-1:0] wr_be
);

  // Command stage (edge N)
  cyc_e             s1_kind, s1_kind_nxt;
  logic [AW-1:0]    s1_base, s1_base_nxt;
  logic [1:0]       s1_beat, s1_beat_nxt;
  logic [LANES-1:0] s1_be,   s1_be_nxt;
  logic [AW-1:0]    s1_eff;

  // Late-write stage (edge N+1), data joins at edge N+2
  cyc_e             s2_kind;
  logic [AW-1:0]    s2_addr;
  logic [LANES-1:0] s2_be;

  logic chip_on, burst_go, new_go;

  assign chip_on  = sel_a & sel_b & ~sel_c_n;
  assign burst_go = ~sleep & adv & (s1_kind != CYC_NONE);
  assign new_go   = ~sleep & ~adv & chip_on;

  assign s1_eff = {s1_base[AW-1:2], burst_lsb(s1_base[1:0], s1_beat, ilv)};

  // Next-state for the command stage
  always_comb begin
    s1_kind_nxt = CYC_NONE;
    s1_base_nxt = s1_base;
    s1_beat_nxt = s1_beat;
    s1_be_nxt   = be;
    if (burst_go) begin
      s1_kind_nxt = s1_kind;
      s1_beat_nxt = s1_beat + 2'd1;
    end else if (new_go) begin
      s1_kind_nxt = wr_sel ? CYC_WR : CYC_RD;
      s1_base_nxt = addr;
      s1_beat_nxt = 2'd0;
    end
  end

  // Registers, advanced only on enabled edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_kind <= CYC_NONE;
      s1_base <= '0;
      s1_beat <= 2'd0;
      s1_be   <= '0;
      s2_kind <= CYC_NONE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (ce) begin
      s1_kind <= s1_kind_nxt;
      s1_base <= s1_base_nxt;
      s1_beat <= s1_beat_nxt;
      s1_be   <= s1_be_nxt;
      s2_kind <= s1_kind;
      s2_addr <= s1_eff;
      s2_be   <= s1_be;
    end
  end

  assign rd_fire = (s1_kind == CYC_RD);
  assign rd_addr = s1_eff;
  assign wr_fire = (s2_kind == CYC_WR);
  assign wr_addr = s2_addr;
  assign wr_be   = s2_be;

  // A suspended edge leaves the command stage untouched
  assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(s1_kind) && $stable(s1_base) && $stable(s1_beat) && $stable(s2_kind)));

  // An accepted advance keeps type and base, steps the beat by one
  assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !sleep && adv && s1_kind != CYC_NONE) |=>
      (s1_beat == $past(s1_beat) + 2'd1 && s1_base == $past(s1_base) && s1_kind == $past(s1_kind)));

  // Sleep accepts nothing
  assert_sleep_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && sleep) |=> (s1_kind == CYC_NONE));

  // A failed select without advance is a deselect
  assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !adv && !(sel_a && sel_b && !sel_c_n)) |=> (s1_kind == CYC_NONE));

endmodule

// File: rtl/ntsram_array.sv
module ntsram_array #(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    ce,
  input  logic                    wr_fire,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  logic wr_ok, rd_ok;
  assign wr_ok = (int'(wr_addr) < DEPTH);
  assign rd_ok = (int'(rd_addr) < DEPTH);

  // One storage column per byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (ce && wr_fire && wr_be[g] && wr_ok) begin
        mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_ok ? mem[rd_addr] : '0;
  end

endmodule

// File: rtl/ntsram_outreg.sv
module ntsram_outreg #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    oe,
  input  logic                    rd_fire,
  input  logic [AW-1:0]           rd_addr,
  input  logic [LANES*LANE_W-1:0] arr_data,
  input  logic                    wr_fire,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_drive
);

  localparam int W = LANES * LANE_W;

  logic [W-1:0] merged, q_reg, q_reg_nxt;
  logic         q_valid, q_valid_nxt;
  logic         hit;

  assign hit = wr_fire && (wr_addr == rd_addr);

  // Per-lane forward from the write completing at this edge
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (hit && wr_be[g]) ? wdata[g*LANE_W +: LANE_W]
                                                          : arr_data[g*LANE_W +: LANE_W];
  end

  always_comb begin
    q_valid_nxt = rd_fire;
    q_reg_nxt   = rd_fire ? merged : q_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else if (ce) q_valid <= q_valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (ce) q_reg <= q_reg_nxt;
  end

  assign q_drive = oe & q_valid;
  assign q       = q_drive ? q_reg : '0;

  // A full-lane hit returns exactly the write data
  assert_forward_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && rd_fire && hit && (&wr_be)) |=> (q_reg == $past(wdata)));

endmodule

// File: rtl/ntsram_top.sv
module ntsram_top #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_sel,
  input  logic             adv,
  input  logic             burst_ilv,
  input  logic [LANES-1:0] byte_we,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  input  logic             oe,
  input  logic             sleep,
  output logic [W-1:0]     q,
  output logic             q_drive
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic             rd_fire, wr_fire;
  logic [AW-1:0]    rd_addr, wr_addr;
  logic [LANES-1:0] wr_be;
  logic [W-1:0]     arr_data;

  ntsram_ctrl #(.AW(AW), .LANES(LANES)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_q),
    .ce      (clk_en),
    .sleep   (sleep),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .sel_c_n (sel_c_n),
    .wr_sel  (wr_sel),
    .adv     (adv),
    .ilv     (burst_ilv),
    .be      (byte_we),
    .addr    (addr),
    .rd_fire (rd_fire),
    .rd_addr (rd_addr),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_be   (wr_be)
  );

  ntsram_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk     (clk),
    .ce      (clk_en),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_be   (wr_be),
    .wdata   (wdata),
    .rd_addr (rd_addr),
    .rd_data (arr_data)
  );

  ntsram_outreg #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) outreg_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .ce       (clk_en),
    .oe       (oe),
    .rd_fire  (rd_fire),
    .rd_addr  (rd_addr),
    .arr_data (arr_data),
    .wr_fire  (wr_fire),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .wdata    (wdata),
    .q        (q),
    .q_drive  (q_drive)
  );

  // A read leaving the command stage is on the bus one enabled edge later
  assert_read_out_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (clk_en && rd_fire) |=> (q_drive == oe));

endmodule

// File: tb/ntsram_top_tb_top.sv
`timescale 1ns/1ps
module ntsram_top_tb_top;

  localparam logic [2:0] SEL_OK = 3'b110;
  localparam logic [2:0] BAD_A  = 3'b010;
  localparam logic [2:0] BAD_B  = 3'b100;
  localparam logic [2:0] BAD_C  = 3'b111;

  logic        clk = 1'b0;
  logic        rst_n, clk_en, sel_a, sel_b, sel_c_n, wr_sel, adv, burst_ilv, oe, sleep;
  logic [3:0]  byte_we;
  logic [7:0]  addr;
  logic [35:0] wdata, q;
  logic        q_drive;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  ntsram_top dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_sel(wr_sel), .adv(adv), .burst_ilv(burst_ilv),
    .byte_we(byte_we), .addr(addr), .wdata(wdata), .oe(oe), .sleep(sleep),
    .q(q), .q_drive(q_drive)
  );

  function automatic logic [35:0] dv(input int k);
    return {9'(k*4+3), 9'(k*4+2), 9'(k*4+1), 9'(k*4)};
  endfunction

  function automatic logic [35:0] mix(input logic [35:0] nw, input logic [35:0] old,
                                      input logic [3:0] m);
    logic [35:0] r;
    for (int i = 0; i < 4; i++) r[i*9 +: 9] = m[i] ? nw[i*9 +: 9] : old[i*9 +: 9];
    return r;
  endfunction

  // One command slot, driven at the falling edge
  task automatic slot(input logic c, input logic [2:0] s, input logic w, input logic a,
                      input logic [3:0] b, input logic [7:0] ad, input logic [35:0] d);
    @(negedge clk);
    clk_en = c; {sel_a, sel_b, sel_c_n} = s; wr_sel = w; adv = a;
    byte_we = b; addr = ad; wdata = d;
  endtask

  task automatic rd(input logic [7:0] ad, input logic [35:0] d);
    slot(1'b1, SEL_OK, 1'b0, 1'b0, 4'hf, ad, d);
  endtask
  task automatic wr(input logic [7:0] ad, input logic [3:0] b, input logic [35:0] d);
    slot(1'b1, SEL_OK, 1'b1, 1'b0, b, ad, d);
  endtask
  task automatic idle(input logic [35:0] d);
    slot(1'b1, BAD_A, 1'b0, 1'b0, 4'h0, 8'h00, d);
  endtask

  task automatic chk(input string tag, input logic exp_drv, input logic [35:0] exp_q);
    checks++;
    if (q_drive !== exp_drv || q !== exp_q) begin
      errors++;
      $display("FAIL %s: actual drive=%0b q=%h expected drive=%0b q=%h",
               tag, q_drive, q, exp_drv, exp_q);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset state", 1'b0, 36'h0);
  endtask

  task automatic t_mix;
    wr(8'd4, 4'hf, '0);
    wr(8'd5, 4'hf, '0);
    rd(8'd4, dv(40));
    rd(8'd5, dv(50));
    idle('0);   chk("R2 R3 read after write", 1'b1, dv(40));
    idle('0);   chk("R4 write-write-read-read", 1'b1, dv(50));
    rd(8'd4, '0);
    wr(8'd6, 4'hf, '0);
    wr(8'd7, 4'hf, '0); chk("R4 read then write", 1'b1, dv(40));
    idle(dv(60)); chk("R2 write slot not driven", 1'b0, 36'h0);
    idle(dv(70));
    rd(8'd6, '0);
    rd(8'd7, '0);
    idle('0);   chk("R4 write after read addr6", 1'b1, dv(60));
    idle('0);   chk("R4 write after read addr7", 1'b1, dv(70));
  endtask

  task automatic t_forward;
    wr(8'd10, 4'hf, '0);
    rd(8'd10, '0);
    idle(dv(100));
    idle('0);   chk("R5 full-lane forward", 1'b1, dv(100));
    wr(8'd9, 4'hf, '0);
    idle('0);
    idle(dv(90));
    wr(8'd9, 4'b0101, '0);
    rd(8'd9, '0);
    idle(dv(91));
    idle('0);   chk("R5 R3 partial-lane forward", 1'b1, mix(dv(91), dv(90), 4'b0101));
    rd(8'd9, '0);
    idle('0);
    idle('0);   chk("R3 lane mask in array", 1'b1, mix(dv(91), dv(90), 4'b0101));
  endtask

  task automatic t_burst;
    burst_ilv = 1'b0;
    wr(8'h11, 4'hf, '0);
    slot(1'b1, BAD_B, 1'b0, 1'b1, 4'hf, 8'hff, '0);
    slot(1'b1, BAD_A, 1'b0, 1'b1, 4'hf, 8'h00, dv(200));
    slot(1'b1, BAD_C, 1'b0, 1'b1, 4'hf, 8'h33, dv(201));
    idle(dv(202));
    idle(dv(203));
    burst_ilv = 1'b1;
    rd(8'h11, '0);
    slot(1'b1, BAD_A, 1'b1, 1'b1, 4'hf, 8'hee, '0);
    slot(1'b1, BAD_B, 1'b1, 1'b1, 4'hf, 8'h44, '0); chk("R9 R10 beat0 at 0x11", 1'b1, dv(200));
    slot(1'b1, BAD_C, 1'b1, 1'b1, 4'hf, 8'h55, '0); chk("R10 beat1 at 0x10", 1'b1, dv(203));
    slot(1'b1, SEL_OK, 1'b1, 1'b1, 4'hf, 8'h66, '0); chk("R10 beat2 at 0x13", 1'b1, dv(202));
    idle('0);   chk("R9 R10 beat3 at 0x12", 1'b1, dv(201));
    idle('0);   chk("R8 wrap to beat0", 1'b1, dv(200));
    burst_ilv = 1'b0;
    slot(1'b1, BAD_A, 1'b0, 1'b1, 4'hf, 8'h11, '0);
    idle('0);
    idle('0);   chk("R8 advance after deselect", 1'b0, 36'h0);
  endtask

  task automatic t_suspend;
    idle('0); idle('0); idle('0);
    rd(8'd4, '0);
    slot(1'b0, SEL_OK, 1'b1, 1'b0, 4'hf, 8'd4, dv(999));
    slot(1'b0, SEL_OK, 1'b1, 1'b0, 4'hf, 8'd4, dv(999));
    slot(1'b0, SEL_OK, 1'b1, 1'b0, 4'hf, 8'd4, dv(999)); chk("R6 output held while suspended", 1'b0, 36'h0);
    idle(dv(998));
    idle(dv(997)); chk("R6 read resumes after suspend", 1'b1, dv(40));
    rd(8'd4, '0);
    idle('0);
    idle('0);   chk("R6 suspended write ignored", 1'b1, dv(40));
  endtask

  task automatic t_select;
    logic [2:0] bad [3] = '{BAD_A, BAD_B, BAD_C};
    for (int i = 0; i < 3; i++) begin
      slot(1'b1, bad[i], 1'b0, 1'b0, 4'hf, 8'd5, '0);
      idle('0);
      idle('0); chk("R7 deselected read not driven", 1'b0, 36'h0);
    end
    slot(1'b1, BAD_C, 1'b1, 1'b0, 4'hf, 8'd5, '0);
    idle('0);
    idle(dv(777));
    rd(8'd5, '0);
    idle('0);
    idle('0);   chk("R7 deselected write ignored", 1'b1, dv(50));
  endtask

  task automatic t_sleep;
    sleep = 1'b1;
    rd(8'd6, '0);
    wr(8'd6, 4'hf, '0);
    slot(1'b1, SEL_OK, 1'b0, 1'b1, 4'hf, 8'd6, dv(555));
    idle(dv(556)); chk("R12 no read in sleep", 1'b0, 36'h0);
    sleep = 1'b0;
    rd(8'd6, '0);
    idle('0);
    idle('0);   chk("R12 no write in sleep", 1'b1, dv(60));
  endtask

  task automatic t_oe;
    rd(8'd7, '0);
    idle('0);
    idle('0);
    oe = 1'b0; #1;
    chk("R11 oe low floats at once", 1'b0, 36'h0);
    oe = 1'b1; #1;
    chk("R11 oe high shows held word", 1'b1, dv(70));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; {sel_a, sel_b, sel_c_n} = BAD_A; wr_sel = 1'b0;
    adv = 1'b0; burst_ilv = 1'b0; byte_we = 4'h0; addr = '0; wdata = '0;
    oe = 1'b1; sleep = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset;
    t_mix;
    t_forward;
    t_burst;
    t_suspend;
    t_select;
    t_sleep;
    t_oe;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule